// File: doc/BRIEF.md
# Power Management Capability Register Block

This block holds one power management capability structure in a function's configuration space. It occupies two consecutive dwords, and the byte offset of the first dword is set by a parameter. The first dword identifies the capability and links to the next capability. It also carries a read-only word that describes the power features the function supports. The second dword holds four things:

- a control and status word, which holds the current power state, the PME enable, the PME status bit, a data-select field and a dynamic-reporting enable;
- a bridge extension byte;
- a data byte;
- a read-only scale factor that belongs to the data byte.

The data byte shows one of eight measured power values. These values come in on input pins. The data-select field picks the value that is shown.

Configuration reads and writes are single-cycle strobes addressed by dword index, and writes carry byte enables. The block drives the current power state on a port, and the platform logic uses it to change power states. The block also drives a PME request. The PME status bit is set by an external wake event. It is also set when dynamic reporting is enabled and the selected measurement moves further from its last reported value than a parameter threshold allows. Software clears the bit by writing a 1 to it.

Top module: `pm_cap_regs`

## Requirements
- R1: A read of dword index CAP_BASE/4 returns byte 0 = 01h, byte 1 = NEXT_PTR, and bits 31:16 = the capability word. The capability word has version 001 in bits 18:16, DSI in bit 21, D1 support in bit 25, D2 support in bit 26 and the PME-capable states (D0, D1, D2) in bits 30:28. Writes to this dword have no effect. A read of any dword outside the structure returns 0. Read data appears on cfg_rdata in the cycle after cfg_rd.
- R2: After reset, the following are all 0: the power state (D0), PME enable, PME status, data select, dynamic enable, the bridge dynamic-clock bit and pme_out.
- R3: Control bits 1:0 of the second dword (00 = D0, 01 = D1, 10 = D2, 11 = D3) are read-write when byte enable 0 is set, and they drive pwr_state. A write with byte enable 0 clear leaves them unchanged.
- R4: A write that requests D1 while D1_SUP = 0, or D2 while D2_SUP = 0, is ignored, and the previous state is kept.
- R5: PME status (bit 15) is set by wake_evt. A write of 1 to bit 15 with byte enable 1 clears it, and a write of 0 does not change it. If a set event and a clear arrive in the same cycle, the bit ends up set.
- R6: pme_out is high exactly when both PME status and PME enable (bit 8) are set. It is registered and changes on the same edge as the bits that drive it.
- R7: Data select (bits 12:9) values 0 to 7 place measurement number N (meas_data bits 8N+7:8N) in bits 31:24. Bits 14:13 always read SCALE, and writes to them, or to bits 31:24, are ignored.
- R8: Data select values 8 to 15 make bits 31:24 read 00h.
- R9: When dynamic reporting (bit 4) is set, PME status is set if the selected measurement differs from the reference value by more than THRESH, in either direction. A difference equal to THRESH does not set it. Each trigger loads the reference with the current value. While bit 4 is clear, the reference follows the selected measurement.
- R10: The bridge byte (bits 23:16) reads BUS_PWR_CTL in bit 23, B3_SUP in bit 22 and B2_SUP in bit 21, and these bits are read-only. Bit 20 is the read-write dynamic clock control enable. Bits 19:16 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword index within configuration space (byte offset / 4) |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Write byte enables |
| cfg_rdata | output | 32 | Read data, valid the cycle after cfg_rd |
| meas_data | input | 64 | Eight 8-bit measured power values, item N in bits 8N+7:8N |
| wake_evt | input | 1 | External wake event, sets PME status |
| pme_out | output | 1 | PME request |
| pwr_state | output | 2 | Current power state |

## Verification
The bench requests the unsupported D2 state, which a block that did not filter requests would accept. It selects a reserved data item, which a block that indexed past the measurement table would answer with stale or random data. It writes 0 to PME status and raises a wake event in the same cycle as a 1-to-clear, which catches a block that clears on any write or lets the clear win. For dynamic reporting, it steps the measurement by exactly the threshold and then by one more, moves it downward, and makes a small step after a trigger. A block with an off-by-one comparison, an unsigned difference, or a reference value that is never reloaded shows a spurious or missing PME on one of these steps. A large jump while reporting is disabled exposes a reference that does not follow the measurement.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwr_state_e;

  localparam logic [7:0] PM_CAP_ID   = 8'h01;
  localparam logic [2:0] PM_SPEC_VER = 3'b001;
  localparam int         ITEM_W      = 8;   // data byte width, fixed by layout
  localparam int         NUM_ITEMS   = 8;   // defined data-select items
  localparam int         SEL_W       = 4;   // data-select field width

  // Read-only capability word assembled from feature parameters
  function automatic logic [15:0] caps_word(input logic dsi, input logic d1,
                                            input logic d2, input logic [2:0] pme_sup);
    logic [15:0] w;
    w         = '0;
    w[2:0]    = PM_SPEC_VER;
    w[5]      = dsi;
    w[9]      = d1;
    w[10]     = d2;
    w[14:12]  = pme_sup;
    return w;
  endfunction

endpackage

// File: rtl/pm_data_mux.sv
module pm_data_mux
  import pm_cap_pkg::*;
#(
  parameter int W     = ITEM_W,
  parameter int N     = NUM_ITEMS,
  parameter int SW    = SEL_W
) (
  input  logic [N*W-1:0] meas,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   item
);
  localparam int IDX_W = $clog2(N);

  logic [W-1:0] items [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_item
      assign items[i] = meas[i*W +: W];
    end
  endgenerate

  always_comb begin
    if (sel < SW'(N)) item = items[sel[IDX_W-1:0]];
    else              item = '0;
  end

endmodule

// File: rtl/pm_dyn_detect.sv
module pm_dyn_detect #(
  parameter int          W      = 8,
  parameter logic [7:0]  THRESH = 8'd4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] cur,
  output logic         trig
);
  logic [W-1:0] ref_q;
  logic [W-1:0] diff;

  always_comb begin
    diff = (cur >= ref_q) ? (cur - ref_q) : (ref_q - cur);
    trig = en && (diff > W'(THRESH));
  end

  always_ff @(posedge clk) begin
    if (rst)                ref_q <= '0;
    else if (!en || trig)   ref_q <= cur;
  end

  // R9
  dyn_no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> (!trig || cur != $past(cur)));

endmodule

// File: rtl/pm_csr.sv
module pm_csr
  import pm_cap_pkg::*;
#(
  parameter bit D1_SUP = 1'b1,
  parameter bit D2_SUP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_be,
  input  logic [7:0]       wr_b0,
  input  logic [7:0]       wr_b1,
  input  logic [7:0]       wr_b2,
  input  logic             wake_evt,
  input  logic             dyn_trig,
  output logic [1:0]       state,
  output logic             pme_en,
  output logic             pme_status,
  output logic [SEL_W-1:0] data_sel,
  output logic             dyn_en,
  output logic             dyn_clk_en,
  output logic             pme_out
);
  pwr_state_e state_q;
  logic       set_evt, clr_req, st_nxt, en_nxt, req_ok;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{wr_b0[7:5], wr_b0[3:2], wr_b1[6:5], wr_b2[7:5], wr_b2[3:0]};

  always_comb begin
    set_evt = wake_evt | dyn_trig;
    clr_req = wr_en && wr_be[1] && wr_b1[7];
    st_nxt  = set_evt ? 1'b1 : (clr_req ? 1'b0 : pme_status);
    en_nxt  = (wr_en && wr_be[1]) ? wr_b1[0] : pme_en;
    unique case (wr_b0[1:0])
      2'b01:   req_ok = D1_SUP;
      2'b10:   req_ok = D2_SUP;
      default: req_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PS_D0;
      pme_en     <= 1'b0;
      pme_status <= 1'b0;
      data_sel   <= '0;
      dyn_en     <= 1'b0;
      dyn_clk_en <= 1'b0;
      pme_out    <= 1'b0;
    end else begin
      if (wr_en && wr_be[0]) begin
        if (req_ok) state_q <= pwr_state_e'(wr_b0[1:0]);
        dyn_en <= wr_b0[4];
      end
      if (wr_en && wr_be[1]) data_sel <= wr_b1[4:1];
      if (wr_en && wr_be[2]) dyn_clk_en <= wr_b2[4];
      pme_en     <= en_nxt;
      pme_status <= st_nxt;
      pme_out    <= st_nxt & en_nxt;
    end
  end

  assign state = state_q;

  // R4
  no_d2_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[0] && wr_b0[1:0] == 2'b10 && !D2_SUP) |=> state == $past(state));
  // R4
  no_d1_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[0] && wr_b0[1:0] == 2'b01 && !D1_SUP) |=> state == $past(state));
  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !set_evt) |=> !pme_status);
  // R5
  status_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pme_status) |-> $past(set_evt));
  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == 2'b00 && !pme_out && !pme_status));

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
  import pm_cap_pkg::*;
#(
  parameter logic [7:0] CAP_BASE    = 8'h40,
  parameter logic [7:0] NEXT_PTR    = 8'h50,
  parameter bit         D1_SUP      = 1'b1,
  parameter bit         D2_SUP      = 1'b0,
  parameter logic [2:0] PME_SUP     = 3'b011,
  parameter bit         DSI         = 1'b0,
  parameter logic [1:0] SCALE       = 2'b01,
  parameter bit         BUS_PWR_CTL = 1'b1,
  parameter bit         B3_SUP      = 1'b0,
  parameter bit         B2_SUP      = 1'b1,
  parameter logic [7:0] THRESH      = 8'd4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_rd,
  input  logic                      cfg_wr,
  input  logic [5:0]                cfg_addr,
  input  logic [31:0]               cfg_wdata,
  input  logic [3:0]                cfg_be,
  output logic [31:0]               cfg_rdata,
  input  logic [NUM_ITEMS*ITEM_W-1:0] meas_data,
  input  logic                      wake_evt,
  output logic                      pme_out,
  output logic [1:0]                pwr_state
);
  localparam logic [5:0]  HDR_DW = CAP_BASE[7:2];
  localparam logic [5:0]  CTL_DW = HDR_DW + 6'd1;
  localparam logic [15:0] CAPS   = caps_word(DSI, D1_SUP, D2_SUP, PME_SUP);

  logic             ctl_wr;
  logic             pme_en, pme_status, dyn_en, dyn_clk_en, dyn_trig;
  logic [SEL_W-1:0] data_sel;
  logic [ITEM_W-1:0] sel_item;
  logic [15:0]      csr_word;
  logic [7:0]       bridge_byte;
  logic             unused_top;

  assign unused_top = ^{cfg_wdata[31:24], cfg_be[3]};
  assign ctl_wr     = cfg_wr && (cfg_addr == CTL_DW);

  pm_csr #(.D1_SUP(D1_SUP), .D2_SUP(D2_SUP)) u_csr (
    .clk(clk), .rst(rst), .wr_en(ctl_wr), .wr_be(cfg_be[2:0]),
    .wr_b0(cfg_wdata[7:0]), .wr_b1(cfg_wdata[15:8]), .wr_b2(cfg_wdata[23:16]),
    .wake_evt(wake_evt), .dyn_trig(dyn_trig),
    .state(pwr_state), .pme_en(pme_en), .pme_status(pme_status),
    .data_sel(data_sel), .dyn_en(dyn_en), .dyn_clk_en(dyn_clk_en), .pme_out(pme_out)
  );

  pm_data_mux #(.W(ITEM_W), .N(NUM_ITEMS), .SW(SEL_W)) u_mux (
    .meas(meas_data), .sel(data_sel), .item(sel_item)
  );

  pm_dyn_detect #(.W(ITEM_W), .THRESH(THRESH)) u_dyn (
    .clk(clk), .rst(rst), .en(dyn_en), .cur(sel_item), .trig(dyn_trig)
  );

  always_comb begin
    csr_word        = '0;
    csr_word[15]    = pme_status;
    csr_word[14:13] = SCALE;
    csr_word[12:9]  = data_sel;
    csr_word[8]     = pme_en;
    csr_word[4]     = dyn_en;
    csr_word[1:0]   = pwr_state;
    bridge_byte     = {BUS_PWR_CTL, B3_SUP, B2_SUP, dyn_clk_en, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (rst)              cfg_rdata <= '0;
    else if (cfg_rd) begin
      if (cfg_addr == HDR_DW)      cfg_rdata <= {CAPS, NEXT_PTR, PM_CAP_ID};
      else if (cfg_addr == CTL_DW) cfg_rdata <= {sel_item, bridge_byte, csr_word};
      else                         cfg_rdata <= '0;
    end
  end

  // R1
  hdr_id_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr == HDR_DW) |=> cfg_rdata[7:0] == PM_CAP_ID);
  // R8
  reserved_item_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr == CTL_DW && data_sel[3]) |=> cfg_rdata[31:24] == 8'h00);
  // R10
  bridge_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_addr == CTL_DW) |=> cfg_rdata[19:16] == 4'h0);

endmodule

// File: tb/pm_cap_regs_test.sv
module pm_cap_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_rd = 1'b0, cfg_wr = 1'b0, wake_evt = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] meas_data;
  logic        pme_out;
  logic [1:0]  pwr_state;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;  // 250 MHz

  pm_cap_regs uut (
    .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .meas_data(meas_data), .wake_evt(wake_evt), .pme_out(pme_out), .pwr_state(pwr_state)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  dw;
    logic [31:0] wd;
    logic [3:0]  be;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h10, 32'h0, 4'h0, 32'h3201_5001, 4'd1},   // R1 header
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20A0_2000, 4'd10},  // R10 bridge/scale after reset
    '{1'b0, 6'h12, 32'h0, 4'h0, 32'h0,         4'd1},   // R1 outside
    '{1'b0, 6'h0F, 32'h0, 4'h0, 32'h0,         4'd1},   // R1 outside
    '{1'b1, 6'h11, 32'h3,    4'h1, 32'h0, 4'd3},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20A0_2003, 4'd3},   // R3 D3
    '{1'b1, 6'h11, 32'h2,    4'h1, 32'h0, 4'd4},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20A0_2003, 4'd4},   // R4 D2 refused
    '{1'b1, 6'h11, 32'h1,    4'h1, 32'h0, 4'd3},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20A0_2001, 4'd3},   // R3 D1 accepted
    '{1'b1, 6'h11, 32'h0A00, 4'h2, 32'h0, 4'd7},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h25A0_2A01, 4'd7},   // R7 item 5
    '{1'b1, 6'h11, 32'h1200, 4'h2, 32'h0, 4'd8},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h00A0_3201, 4'd8},   // R8 item 9
    '{1'b1, 6'h11, 32'h6000, 4'h2, 32'h0, 4'd7},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20A0_2001, 4'd7},   // R7 scale RO
    '{1'b1, 6'h11, 32'h00FF_0000, 4'h4, 32'h0, 4'd10},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20B0_2001, 4'd10},  // R10 bit 20 only
    '{1'b1, 6'h10, 32'hFFFF_FFFF, 4'hF, 32'h0, 4'd1},
    '{1'b0, 6'h10, 32'h0, 4'h0, 32'h3201_5001, 4'd1},   // R1 header RO
    '{1'b1, 6'h11, 32'h3,    4'h0, 32'h0, 4'd3},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20B0_2001, 4'd3},   // R3 no byte enable
    '{1'b1, 6'h11, 32'hFF00_0000, 4'h8, 32'h0, 4'd7},
    '{1'b0, 6'h11, 32'h0, 4'h0, 32'h20B0_2001, 4'd7}    // R7 data byte RO
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic set_item(input int i, input logic [7:0] v);
    @(negedge clk);
    meas_data[i*8 +: 8] = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) meas_data[i*8 +: 8] = 8'h20 + 8'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R2 pwr_state", {30'b0, pwr_state}, 32'h0);
    check("R2 pme_out", {31'b0, pme_out}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wr) cfg_write(VECS[v].dw, VECS[v].wd, VECS[v].be);
      else begin
        cfg_read(VECS[v].dw, rd);
        check($sformatf("R%0d vector %0d", VECS[v].req, v), rd, VECS[v].exp);
      end
    end
    check("R3 pwr_state port", {30'b0, pwr_state}, 32'h1);

    // R5/R6: wake with enable clear
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    check("R6 pme_out gated by enable", {31'b0, pme_out}, 32'h0);
    cfg_read(6'h11, rd); check("R5 status set by wake", rd, 32'h20B0_A001);
    cfg_write(6'h11, 32'h0100, 4'h2);
    check("R6 pme_out after enable", {31'b0, pme_out}, 32'h1);
    cfg_read(6'h11, rd); check("R5 write 0 keeps status", rd, 32'h20B0_A101);
    cfg_write(6'h11, 32'h8100, 4'h2);
    check("R6 pme_out after clear", {31'b0, pme_out}, 32'h0);
    cfg_read(6'h11, rd); check("R5 w1c", rd, 32'h20B0_2101);
    // R5: set wins over clear
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 6'h11; cfg_wdata = 32'h8100; cfg_be = 4'h2; wake_evt = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; wake_evt = 1'b0;
    cfg_read(6'h11, rd); check("R5 set beats clear", rd, 32'h20B0_A101);
    cfg_write(6'h11, 32'h8100, 4'h2);

    // R9: dynamic reporting on item 2
    cfg_write(6'h11, 32'h0500, 4'h2);
    cfg_write(6'h11, 32'h0011, 4'h1);
    set_item(2, 8'h25);
    cfg_read(6'h11, rd); check("R9 small step", rd, 32'h25B0_2511);
    set_item(2, 8'h27);
    check("R9 pme_out on trigger", {31'b0, pme_out}, 32'h1);
    cfg_read(6'h11, rd); check("R9 large step", rd, 32'h27B0_A511);
    cfg_write(6'h11, 32'h8500, 4'h2);
    set_item(2, 8'h2A);
    cfg_read(6'h11, rd); check("R9 reference reloaded", rd, 32'h2AB0_2511);
    set_item(2, 8'h20);
    cfg_read(6'h11, rd); check("R9 downward step", rd, 32'h20B0_A511);
    cfg_write(6'h11, 32'h8500, 4'h2);
    set_item(2, 8'h24);
    cfg_read(6'h11, rd); check("R9 step equal to threshold", rd, 32'h24B0_2511);
    cfg_write(6'h11, 32'h0001, 4'h1);
    set_item(2, 8'h60);
    cfg_read(6'h11, rd); check("R9 disabled jump", rd, 32'h60B0_2501);
    cfg_write(6'h11, 32'h0011, 4'h1);
    set_item(2, 8'h62);
    cfg_read(6'h11, rd); check("R9 reference tracked while off", rd, 32'h62B0_2511);

    // R2: reset again
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R2 pwr_state after reset", {30'b0, pwr_state}, 32'h0);
    check("R2 pme_out after reset", {31'b0, pme_out}, 32'h0);
    cfg_read(6'h11, rd); check("R2 control word after reset", rd, 32'h20A0_2000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule